// File: doc/BRIEF.md
# Host Bridge Error Router

This block gathers the error events seen by a host-to-PCI bridge and turns them into the bridge's outgoing error indications. On the host side these are an address-error line, a bus-error line and a bus-init line. Toward the system they are the PCI system-error line (SERR#) and a hard-fail output. A 32-bit control register chooses which events are acted on. One control bit sends every reportable error either to the hard-fail output or to SERR#. A small status register records, in sticky flags, the events that occurred, whether or not they were reported.

The block also contains the host bus watchdog. When a host transaction starts, the watchdog loads one of two timeout lengths. If nobody claims the transaction before the count runs out, the bridge claims and completes it itself. The block tells the read datapath to return all-ones data for reads that time out and for reads that end in a PCI master abort. All outputs are registered and appear in the clock cycle after the event that causes them. Reset is asserted asynchronously and released synchronously inside the block, two clocks after `rst_n` rises.

Top module: `herr_route`

## Requirements
- R1: Control bit 13 selects the reporting path for master-abort and host-timeout reports. When the bit is 1 a report pulses `hfail_o` and leaves `serr_o` low. When it is 0 the report pulses `serr_o` and leaves `hfail_o` low.
- R2: A PCI parity error (`evt_pci_perr`) pulses `serr_o` when `serr_cmd_en` is 1. It never drives `hfail_o`, whatever bit 13 holds.
- R3: A PCI master abort always sets status bit 0. It is reported only when control bit 12 is 1. If it ended a read (`evt_ma_read`), `rd_ones_o` pulses whether or not the abort is reported.
- R4: With control bit 8 at 1, a host transaction starting in cycle s and not claimed (`htx_claimed`) in cycles s+1 to s+L expires in cycle s+L. `wdt_claim_o` then pulses in cycle s+L+1, and for a read `rd_ones_o` pulses too. L is the short or the long limit, chosen by `wdt_long_sel` at the start. With bit 8 at 0 nothing expires. A claim in the last cycle prevents expiry.
- R5: A watchdog expiry always sets status bit 1. It is reported through the R1 path only when control bit 9 is 1.
- R6: With control bit 7 at 1, an incoming address error (`in_aerr`) pulses `serr_o` only when both `cap_aerr_nmi` and `serr_cmd_en` are 1.
- R7: With control bit 6 at 1, an incoming bus error (`in_berr`) pulses `serr_o` only when `cap_berr_nmi` is 1.
- R8: `binit_o` pulses on `in_berr` when control bit 4 is 1, and on a protocol violation (`evt_proto_viol`) when control bit 3 is 1. A protocol violation always sets status bit 2.
- R9: `berr_o` pulses on `evt_bus_err` when control bit 2 is 1. `aerr_o` pulses on `evt_req_parity` when control bit 0 is 1. With the bits at 0 neither line moves.
- R10: Only control bits 0, 2, 3, 4, 6, 7, 8, 9, 12 and 13 (mask 0x000033DD) store a value. All other bits read as zero.
- R11: Status bits are sticky and reset to zero. Writing with `stat_wr` clears each bit whose `stat_wdata` bit is 1. A new event wins over a clear in the same cycle. Status bit 3 records PCI parity errors.
- R12: After reset every output and register is zero. Each output is high only in the cycle after a qualifying cycle, so a single-cycle event gives a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register contents |
| stat_wr | input | 1 | Write-one-to-clear strobe for the status register |
| stat_wdata | input | 4 | Status bits to clear |
| stat_rdata | output | 4 | Status flags: 0 master abort, 1 host timeout, 2 protocol violation, 3 PCI parity |
| serr_cmd_en | input | 1 | SERR# enable from the PCI command register |
| cap_aerr_nmi | input | 1 | Captured configuration bit that allows address error to SERR# |
| cap_berr_nmi | input | 1 | Captured configuration bit that allows bus error to SERR# |
| wdt_long_sel | input | 1 | Watchdog limit select: 0 short, 1 long |
| evt_req_parity | input | 1 | Request-phase parity error detected |
| evt_bus_err | input | 1 | Bus error detected by the bridge |
| evt_proto_viol | input | 1 | Host bus protocol violation detected |
| evt_pci_perr | input | 1 | PCI data parity error |
| evt_master_abort | input | 1 | PCI master abort on a bridged access |
| evt_ma_read | input | 1 | The aborted access was a read |
| in_aerr | input | 1 | Incoming address-error assertion |
| in_berr | input | 1 | Incoming bus-error assertion |
| htx_start | input | 1 | A host transaction starts |
| htx_is_read | input | 1 | The starting transaction is a read |
| htx_claimed | input | 1 | The current host transaction was claimed |
| aerr_o | output | 1 | Address-error pulse |
| berr_o | output | 1 | Bus-error pulse |
| binit_o | output | 1 | Bus-init pulse |
| serr_o | output | 1 | SERR# request pulse |
| hfail_o | output | 1 | Hard-fail pulse |
| wdt_claim_o | output | 1 | Watchdog claims and completes the transaction |
| rd_ones_o | output | 1 | Return all-ones read data |

## Verification
The hardest state to reach is the watchdog at its deadline. The bench starts a transaction and counts exactly L cycles, so a claim falls in the last allowed cycle or the expiry lands one cycle later. A second hard case is a transaction left waiting with the watchdog disabled. It should expire as soon as the enable is written, and the bench reaches this by writing bit 8 while the transaction is still unclaimed. The bench also lines a master abort up with a clear of the same status bit in one cycle, to exercise the set-over-clear priority.

// File: rtl/herr_pkg.sv
package herr_pkg;

  localparam int CTRL_W = 32;
  localparam int STAT_W = 4;

  // Control bit positions (software-visible layout)
  localparam int CB_AERR_OUT   = 0;
  localparam int CB_BERR_OUT   = 2;
  localparam int CB_BINIT_PROT = 3;
  localparam int CB_BINIT_BERR = 4;
  localparam int CB_SERR_BERR  = 6;
  localparam int CB_SERR_AERR  = 7;
  localparam int CB_WDT_EN     = 8;
  localparam int CB_WDT_RPT    = 9;
  localparam int CB_MA_RPT     = 12;
  localparam int CB_PATH_HF    = 13;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
      (CTRL_W'(1) << CB_AERR_OUT)   | (CTRL_W'(1) << CB_BERR_OUT)  |
      (CTRL_W'(1) << CB_BINIT_PROT) | (CTRL_W'(1) << CB_BINIT_BERR) |
      (CTRL_W'(1) << CB_SERR_BERR)  | (CTRL_W'(1) << CB_SERR_AERR) |
      (CTRL_W'(1) << CB_WDT_EN)     | (CTRL_W'(1) << CB_WDT_RPT)   |
      (CTRL_W'(1) << CB_MA_RPT)     | (CTRL_W'(1) << CB_PATH_HF);

  // Status bit positions
  localparam int SB_MA    = 0;
  localparam int SB_TMO   = 1;
  localparam int SB_PROTO = 2;
  localparam int SB_PERR  = 3;

  typedef struct packed {
    logic aerr_out;
    logic berr_out;
    logic binit_prot;
    logic binit_berr;
    logic serr_berr;
    logic serr_aerr;
    logic wdt_en;
    logic wdt_rpt;
    logic ma_rpt;
    logic path_hf;
  } ctrl_en_t;

  typedef struct packed {
    logic aerr;
    logic berr;
    logic binit;
    logic serr;
    logic hfail;
    logic claim;
    logic ones;
  } err_out_t;

  function automatic ctrl_en_t decode_ctrl(input logic [CTRL_W-1:0] c);
    ctrl_en_t e;
    e.aerr_out   = c[CB_AERR_OUT];
    e.berr_out   = c[CB_BERR_OUT];
    e.binit_prot = c[CB_BINIT_PROT];
    e.binit_berr = c[CB_BINIT_BERR];
    e.serr_berr  = c[CB_SERR_BERR];
    e.serr_aerr  = c[CB_SERR_AERR];
    e.wdt_en     = c[CB_WDT_EN];
    e.wdt_rpt    = c[CB_WDT_RPT];
    e.ma_rpt     = c[CB_MA_RPT];
    e.path_hf    = c[CB_PATH_HF];
    return e;
  endfunction

endpackage

// File: rtl/herr_cfg_regs.sv
module herr_cfg_regs
  import herr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic [STAT_W-1:0] stat_set,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q
);

  logic [CTRL_W-1:0] ctrl_d;
  logic [STAT_W-1:0] stat_d;

  // Only implemented bits are stored; reserved bits stay zero (R10)
  always_comb begin
    ctrl_d = ctrl_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Sticky flags: set beats clear (R11)
  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    logic clr;
    assign clr       = stat_wr & stat_wdata[i];
    assign stat_d[i] = stat_set[i] | (stat_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/herr_watchdog.sv
module herr_watchdog #(
  parameter int SHORT_CYC = 100000,
  parameter int LONG_CYC  = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_en,
  input  logic long_sel,
  input  logic start,
  input  logic start_read,
  input  logic claimed,
  output logic expire,
  output logic expire_read
);

  localparam int LIM_MAX = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LONG_CYC - 1);

  logic             active_q, active_d;
  logic             rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero     = (cnt_q == '0);
  assign expire      = active_q & at_zero & wdt_en & ~claimed & ~start;
  assign expire_read = rd_q;

  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    cnt_d    = cnt_q;
    if (start) begin
      active_d = 1'b1;
      rd_d     = start_read;
      cnt_d    = long_sel ? LOAD_LONG : LOAD_SHORT;
    end else if (claimed || expire) begin
      active_d = 1'b0;
    end else if (active_q && !at_zero) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/herr_router.sv
module herr_router
  import herr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_en_t          en,
  input  logic              serr_cmd_en,
  input  logic              cap_aerr_nmi,
  input  logic              cap_berr_nmi,
  input  logic              evt_req_parity,
  input  logic              evt_bus_err,
  input  logic              evt_proto_viol,
  input  logic              evt_pci_perr,
  input  logic              evt_master_abort,
  input  logic              evt_ma_read,
  input  logic              in_aerr,
  input  logic              in_berr,
  input  logic              wdt_expire,
  input  logic              wdt_expire_read,
  output logic [STAT_W-1:0] stat_set,
  output err_out_t          out_q
);

  err_out_t out_d;
  logic     report;
  logic     serr_direct;

  always_comb begin
    report      = (en.ma_rpt & evt_master_abort) | (en.wdt_rpt & wdt_expire);
    serr_direct = (evt_pci_perr & serr_cmd_en)
                | (en.serr_aerr & in_aerr & cap_aerr_nmi & serr_cmd_en)
                | (en.serr_berr & in_berr & cap_berr_nmi);

    out_d.aerr  = en.aerr_out & evt_req_parity;
    out_d.berr  = en.berr_out & evt_bus_err;
    out_d.binit = (en.binit_berr & in_berr) | (en.binit_prot & evt_proto_viol);
    out_d.serr  = (report & ~en.path_hf) | serr_direct;
    out_d.hfail = report & en.path_hf;
    out_d.claim = wdt_expire;
    out_d.ones  = (evt_master_abort & evt_ma_read) | (wdt_expire & wdt_expire_read);

    stat_set           = '0;
    stat_set[SB_MA]    = evt_master_abort;
    stat_set[SB_TMO]   = wdt_expire;
    stat_set[SB_PROTO] = evt_proto_viol;
    stat_set[SB_PERR]  = evt_pci_perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/herr_route.sv
module herr_route
  import herr_pkg::*;
#(
  parameter int WDT_SHORT_CYC = 100000,
  parameter int WDT_LONG_CYC  = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output logic [31:0] ctrl_rdata,
  input  logic        stat_wr,
  input  logic [3:0]  stat_wdata,
  output logic [3:0]  stat_rdata,
  input  logic        serr_cmd_en,
  input  logic        cap_aerr_nmi,
  input  logic        cap_berr_nmi,
  input  logic        wdt_long_sel,
  input  logic        evt_req_parity,
  input  logic        evt_bus_err,
  input  logic        evt_proto_viol,
  input  logic        evt_pci_perr,
  input  logic        evt_master_abort,
  input  logic        evt_ma_read,
  input  logic        in_aerr,
  input  logic        in_berr,
  input  logic        htx_start,
  input  logic        htx_is_read,
  input  logic        htx_claimed,
  output logic        aerr_o,
  output logic        berr_o,
  output logic        binit_o,
  output logic        serr_o,
  output logic        hfail_o,
  output logic        wdt_claim_o,
  output logic        rd_ones_o
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_set;
  ctrl_en_t          en;
  err_out_t          outs;
  logic              wdt_expire;
  logic              wdt_expire_read;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  herr_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_set   (stat_set),
    .ctrl_q     (ctrl_q),
    .stat_q     (stat_q)
  );

  assign en = decode_ctrl(ctrl_q);

  herr_watchdog #(
    .SHORT_CYC (WDT_SHORT_CYC),
    .LONG_CYC  (WDT_LONG_CYC)
  ) u_wdt (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .wdt_en      (en.wdt_en),
    .long_sel    (wdt_long_sel),
    .start       (htx_start),
    .start_read  (htx_is_read),
    .claimed     (htx_claimed),
    .expire      (wdt_expire),
    .expire_read (wdt_expire_read)
  );

  herr_router u_route (
    .clk              (clk),
    .rst_n            (core_rst_n),
    .en               (en),
    .serr_cmd_en      (serr_cmd_en),
    .cap_aerr_nmi     (cap_aerr_nmi),
    .cap_berr_nmi     (cap_berr_nmi),
    .evt_req_parity   (evt_req_parity),
    .evt_bus_err      (evt_bus_err),
    .evt_proto_viol   (evt_proto_viol),
    .evt_pci_perr     (evt_pci_perr),
    .evt_master_abort (evt_master_abort),
    .evt_ma_read      (evt_ma_read),
    .in_aerr          (in_aerr),
    .in_berr          (in_berr),
    .wdt_expire       (wdt_expire),
    .wdt_expire_read  (wdt_expire_read),
    .stat_set         (stat_set),
    .out_q            (outs)
  );

  assign ctrl_rdata  = ctrl_q;
  assign stat_rdata  = stat_q;
  assign aerr_o      = outs.aerr;
  assign berr_o      = outs.berr;
  assign binit_o     = outs.binit;
  assign serr_o      = outs.serr;
  assign hfail_o     = outs.hfail;
  assign wdt_claim_o = outs.claim;
  assign rd_ones_o   = outs.ones;

endmodule

// File: rtl/herr_route_chk.sv
module herr_route_chk
  import herr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_rdata,
  input logic        stat_wr,
  input logic [3:0]  stat_wdata,
  input logic [3:0]  stat_rdata,
  input logic        serr_cmd_en,
  input logic        evt_req_parity,
  input logic        evt_bus_err,
  input logic        evt_pci_perr,
  input logic        evt_master_abort,
  input logic        evt_ma_read,
  input logic        htx_claimed,
  input logic        aerr_o,
  input logic        berr_o,
  input logic        serr_o,
  input logic        hfail_o,
  input logic        wdt_claim_o,
  input logic        rd_ones_o
);

  AST_HF_NEEDS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    hfail_o |-> $past(ctrl_rdata[CB_PATH_HF])); // R1

  AST_PERR_TO_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pci_perr && serr_cmd_en) |=> serr_o); // R2

  AST_MA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_master_abort |=> stat_rdata[SB_MA]); // R3

  AST_MA_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_master_abort && evt_ma_read) |=> rd_ones_o); // R3

  AST_CLAIM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_claim_o |-> ($past(ctrl_rdata[CB_WDT_EN]) && !$past(htx_claimed))); // R4

  AST_CLAIM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_claim_o |-> stat_rdata[SB_TMO]); // R5

  AST_AERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_o |-> $past(evt_req_parity && ctrl_rdata[CB_AERR_OUT])); // R9

  AST_BERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> $past(evt_bus_err && ctrl_rdata[CB_BERR_OUT])); // R9

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_rdata) & ~($past(stat_wr) ? $past(stat_wdata) : 4'b0000))
      & ~stat_rdata) == 4'b0000)); // R11

  always @(posedge clk) begin
    if (rst_n) begin
      AST_RSVD_ZERO: assert ((ctrl_rdata & ~CTRL_MASK) == 32'h0); // R10
    end
  end

endmodule

bind herr_route herr_route_chk u_chk (.*);

// File: tb/sim_herr_route.sv
`timescale 1ns/1ps
module sim_herr_route;

  localparam int SHORT = 16;
  localparam int LONG  = 40;

  logic        clk, rst_n;
  logic        ctrl_wr;
  logic [31:0] ctrl_wdata, ctrl_rdata;
  logic        stat_wr;
  logic [3:0]  stat_wdata, stat_rdata;
  logic        serr_cmd_en, cap_aerr_nmi, cap_berr_nmi, wdt_long_sel;
  logic        evt_req_parity, evt_bus_err, evt_proto_viol, evt_pci_perr;
  logic        evt_master_abort, evt_ma_read, in_aerr, in_berr;
  logic        htx_start, htx_is_read, htx_claimed;
  logic        aerr_o, berr_o, binit_o, serr_o, hfail_o, wdt_claim_o, rd_ones_o;

  herr_route #(.WDT_SHORT_CYC(SHORT), .WDT_LONG_CYC(LONG)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  cmp_on = 1'b0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int        m_ctrl, m_stat, cyc, m_deadline;
  bit        m_act, m_rd, x_now, rpt;
  bit        e_aerr, e_berr, e_binit, e_serr, e_hfail, e_claim, e_ones;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; cyc = 0; m_deadline = 0; m_act = 0; m_rd = 0;
      e_aerr = 0; e_berr = 0; e_binit = 0; e_serr = 0; e_hfail = 0; e_claim = 0; e_ones = 0;
    end else begin
      x_now = m_act && (cyc >= m_deadline) && m_ctrl[8] && !htx_claimed && !htx_start;
      rpt   = (m_ctrl[12] && evt_master_abort) || (m_ctrl[9] && x_now);
      e_aerr  = m_ctrl[0] && evt_req_parity;
      e_berr  = m_ctrl[2] && evt_bus_err;
      e_binit = (m_ctrl[4] && in_berr) || (m_ctrl[3] && evt_proto_viol);
      e_hfail = m_ctrl[13] && rpt;
      e_serr  = (!m_ctrl[13] && rpt) || (evt_pci_perr && serr_cmd_en)
             || (m_ctrl[7] && in_aerr && cap_aerr_nmi && serr_cmd_en)
             || (m_ctrl[6] && in_berr && cap_berr_nmi);
      e_claim = x_now;
      e_ones  = (evt_master_abort && evt_ma_read) || (x_now && m_rd);
      if (stat_wr) m_stat = m_stat & ~int'(stat_wdata);
      if (evt_master_abort) m_stat = m_stat | 1;
      if (x_now)            m_stat = m_stat | 2;
      if (evt_proto_viol)   m_stat = m_stat | 4;
      if (evt_pci_perr)     m_stat = m_stat | 8;
      if (ctrl_wr) m_ctrl = ctrl_wdata & 32'h0000_33DD;
      if (htx_start) begin
        m_act = 1; m_rd = htx_is_read;
        m_deadline = cyc + (wdt_long_sel ? LONG : SHORT);
      end else if (htx_claimed || x_now) begin
        m_act = 0;
      end
      cyc++;
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R10 ctrl_rdata", ctrl_rdata, m_ctrl);
      chk("R11 stat_rdata", {28'h0, stat_rdata}, m_stat);
      chk("R9 aerr_o", aerr_o, e_aerr);
      chk("R9 berr_o", berr_o, e_berr);
      chk("R8 binit_o", binit_o, e_binit);
      chk("R1 serr_o", serr_o, e_serr);
      chk("R1 hfail_o", hfail_o, e_hfail);
      chk("R4 wdt_claim_o", wdt_claim_o, e_claim);
      chk("R3 rd_ones_o", rd_ones_o, e_ones);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      report_end();
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_wr = 0; ctrl_wdata = '0; stat_wr = 0; stat_wdata = '0;
    serr_cmd_en = 0; cap_aerr_nmi = 0; cap_berr_nmi = 0; wdt_long_sel = 0;
    evt_req_parity = 0; evt_bus_err = 0; evt_proto_viol = 0; evt_pci_perr = 0;
    evt_master_abort = 0; evt_ma_read = 0; in_aerr = 0; in_berr = 0;
    htx_start = 0; htx_is_read = 0; htx_claimed = 0;
    @(negedge clk);
    cmp_on = 1'b1;
    // R12: reset state
    chk("R12 reset ctrl", ctrl_rdata, 0);
    chk("R12 reset stat", {28'h0, stat_rdata}, 0);
    chk("R12 reset outs", {aerr_o, berr_o, binit_o, serr_o, hfail_o, wdt_claim_o, rd_ones_o}, 0);
    rst_n = 1'b1;
    idle(4);

    // R10: reserved bits
    wr_ctrl(32'hFFFF_FFFF);
    chk("R10 writable mask", ctrl_rdata, 32'h0000_33DD);

    // R9: host error outputs
    wr_ctrl(32'h0000_0005);
    evt_req_parity = 1; evt_bus_err = 1; @(negedge clk); evt_req_parity = 0; evt_bus_err = 0;
    chk("R9 aerr enabled", aerr_o, 1);
    chk("R9 berr enabled", berr_o, 1);
    idle(1);
    chk("R12 single-cycle pulse", {aerr_o, berr_o}, 0);
    wr_ctrl(32'h0);
    evt_req_parity = 1; evt_bus_err = 1; @(negedge clk); evt_req_parity = 0; evt_bus_err = 0;
    chk("R9 disabled", {aerr_o, berr_o}, 0);

    // R8: bus-init sources
    wr_ctrl(32'h0000_0018);
    in_berr = 1; @(negedge clk); in_berr = 0;
    chk("R8 binit from in_berr", binit_o, 1);
    evt_proto_viol = 1; @(negedge clk); evt_proto_viol = 0;
    chk("R8 binit from protocol", binit_o, 1);
    chk("R8 proto status", stat_rdata[2], 1);
    wr_ctrl(32'h0);
    evt_proto_viol = 1; @(negedge clk); evt_proto_viol = 0;
    chk("R8 binit disabled", binit_o, 0);

    // R6: address error to SERR#
    wr_ctrl(32'h0000_0080);
    cap_aerr_nmi = 1; serr_cmd_en = 0;
    in_aerr = 1; @(negedge clk); in_aerr = 0;
    chk("R6 cmd enable off", serr_o, 0);
    serr_cmd_en = 1;
    in_aerr = 1; @(negedge clk); in_aerr = 0;
    chk("R6 all enabled", serr_o, 1);
    cap_aerr_nmi = 0;
    in_aerr = 1; @(negedge clk); in_aerr = 0;
    chk("R6 captured bit off", serr_o, 0);

    // R7: bus error to SERR#
    wr_ctrl(32'h0000_0040);
    in_berr = 1; @(negedge clk); in_berr = 0;
    chk("R7 captured bit off", serr_o, 0);
    cap_berr_nmi = 1;
    in_berr = 1; @(negedge clk); in_berr = 0;
    chk("R7 captured bit on", serr_o, 1);
    cap_berr_nmi = 0;

    // R3 / R1: master abort
    wr_ctrl(32'h0);
    evt_master_abort = 1; evt_ma_read = 1; @(negedge clk); evt_master_abort = 0; evt_ma_read = 0;
    chk("R3 unreported read ones", rd_ones_o, 1);
    chk("R3 unreported no signal", {serr_o, hfail_o}, 0);
    chk("R3 flag", stat_rdata[0], 1);
    wr_ctrl(32'h0000_1000);
    evt_master_abort = 1; @(negedge clk); evt_master_abort = 0;
    chk("R1 path serr", {serr_o, hfail_o, rd_ones_o}, 3'b100);
    wr_ctrl(32'h0000_3000);
    evt_master_abort = 1; @(negedge clk); evt_master_abort = 0;
    chk("R1 path hard fail", {serr_o, hfail_o}, 2'b01);

    // R2: PCI parity never to hard fail
    evt_pci_perr = 1; @(negedge clk); evt_pci_perr = 0;
    chk("R2 perr serr", serr_o, 1);
    chk("R2 perr no hfail", hfail_o, 0);

    // R11: write-one-to-clear, set beats clear
    chk("R11 before clear", {28'h0, stat_rdata}, 32'hD);
    stat_wr = 1; stat_wdata = 4'b0001; @(negedge clk); stat_wr = 0;
    chk("R11 clear bit0", {28'h0, stat_rdata}, 32'hC);
    stat_wr = 1; stat_wdata = 4'b0001; evt_master_abort = 1;
    @(negedge clk); stat_wr = 0; evt_master_abort = 0;
    chk("R11 set wins", stat_rdata[0], 1);
    stat_wr = 1; stat_wdata = 4'b1111; @(negedge clk); stat_wr = 0; stat_wdata = '0;
    chk("R11 clear all", {28'h0, stat_rdata}, 0);

    // R4 / R5: watchdog short limit, reported on SERR#
    serr_cmd_en = 0;
    wr_ctrl(32'h0000_0300);
    htx_start = 1; htx_is_read = 1; @(negedge clk); htx_start = 0; htx_is_read = 0;
    idle(SHORT - 1);
    chk("R4 not yet expired", wdt_claim_o, 0);
    idle(1);
    chk("R4 expired claim", wdt_claim_o, 1);
    chk("R4 read ones", rd_ones_o, 1);
    chk("R5 reported serr", serr_o, 1);
    chk("R5 timeout flag", stat_rdata[1], 1);

    // R4: claim in the last cycle
    htx_start = 1; @(negedge clk); htx_start = 0;
    idle(SHORT - 1);
    htx_claimed = 1; @(negedge clk); htx_claimed = 0;
    chk("R4 last-cycle claim", wdt_claim_o, 0);
    idle(2);
    chk("R4 no late expiry", wdt_claim_o, 0);

    // R4: disabled, then enabled while waiting
    wr_ctrl(32'h0000_0200);
    htx_start = 1; @(negedge clk); htx_start = 0;
    idle(SHORT + 3);
    chk("R4 disabled no claim", wdt_claim_o, 0);
    wr_ctrl(32'h0000_0300);
    idle(1);
    chk("R4 late enable expires", wdt_claim_o, 1);

    // R4 / R5: long limit, write, unreported
    stat_wr = 1; stat_wdata = 4'b1111; @(negedge clk); stat_wr = 0; stat_wdata = '0;
    wr_ctrl(32'h0000_0100);
    wdt_long_sel = 1;
    htx_start = 1; @(negedge clk); htx_start = 0;
    wdt_long_sel = 0;
    idle(LONG - 1);
    chk("R4 long not yet", wdt_claim_o, 0);
    idle(1);
    chk("R4 long expired", wdt_claim_o, 1);
    chk("R4 write no ones", rd_ones_o, 0);
    chk("R5 unreported", {serr_o, hfail_o}, 0);
    chk("R5 flag regardless", stat_rdata[1], 1);

    idle(4);
    done = 1'b1;
    report_end();
  end

endmodule